// File: doc/BRIEF.md
# Programmable Local Bus Cycle Master

This block turns single read and write requests from a host-side register port into timed cycles on an external 8- or 16-bit peripheral bus. The bus has two chip-select windows. Each request names a window and a byte offset within it. The block adds the window's base and a global shift base to the offset, which gives the bus address. It then runs one cycle, or two byte-wide cycles, with phase lengths taken from configuration counts. When the last cycle ends it pulses `rsp_done` and returns any read data.

The configuration inputs set the following, and all of them may change between requests:
- the bus width;
- which byte lane carries the data in 8-bit mode;
- the byte order;
- whether address and data share the AD pins;
- whether the ALE pin, in separated mode, becomes address bit 10;
- the level at which each control pin is active;
- whether the AD pins are ever driven;
- the six phase counts;
- the base and size of each window.

Top module: `lbus_cycle_master`

## Requirements
- R1: After reset the block behaves as follows:
  - `req_ready` is 1 and `rsp_done` is 0.
  - No chip select is active.
  - Both strobes and ALE are inactive.
  - `lb_ad_oe` is 0.
- R2: The bus address is `offset + window base + shift base`, modulo 2^16. Window w drives only `lb_cs_o[w]`, and holds it active from the first address phase to the end of hold.
- R3: The window size is 2^min(size bits, mode limit). The mode limit is 16 in multiplexed mode, 11 in separated mode with ALE used as address bit 10, and 10 in separated mode with an ALE pulse. A request whose offset is at or above the window size produces the following:
  - no chip select and no strobe;
  - `rsp_done` in the first cycle after acceptance;
  - read data 0.
- R4: A cycle runs through these phases in order:
  1. setup, for S clocks;
  2. ALE, for A clocks;
  3. address hold, for H clocks;
  4. one turnaround clock;
  5. the read or write strobe, for T clocks;
  6. hold, for D clocks.
  
  A zero count lasts one clock. `rsp_done` is high for exactly one clock, directly after the last hold clock.
- R5: In multiplexed mode, AD carries the bus address while ALE is active. During a read strobe, AD is released (`lb_ad_oe` = 0).
- R6: In separated mode with ALE used as address bit 10, the ALE pin always equals bit 10 of the bus address and no ALE pulse is issued. Without that option, one ALE pulse is issued per cycle.
- R7: In 16-bit mode, one bus cycle carries the whole word, and the byte order is the same for reads and writes:
  - In little-endian mode (`cfg_big_end` = 0), host bits [7:0] sit on AD[7:0].
  - In big-endian mode, the two bytes are swapped.
- R8: In 8-bit mode, each enabled host byte gets its own cycle, and the cycles run in ascending address order:
  - Host byte k goes to `base + k` when little-endian, or to `base + 1 - k` when big-endian.
  - Read bytes are assembled into their host positions, and unread bytes are 0.
  - With `req_be` = 00, no cycle runs and the request completes like a rejected one.
- R9: In 8-bit mode the byte travels on AD[7:0] when `cfg_hi_lane` = 0, and on AD[15:8] when it is 1. The lane not in use is driven 0 on writes.
- R10: Read data is captured from `lb_ad_i` on the clock edge that ends the last strobe clock. It is presented on `rsp_rdata` together with `rsp_done`.
- R11: Each bit of `cfg_pol` inverts one pin:
  - bit 0 inverts both chip selects;
  - bit 1 inverts ALE;
  - bit 2 inverts the read strobe;
  - bit 3 inverts the write strobe.
  
  With a bit at 0, that pin uses its default: chip selects and strobes are active low, and ALE is active high.
- R12: With `cfg_oe_en` = 0, `lb_ad_oe` stays 0 at all times, while chip selects and strobes still run.
- R13: A request is accepted only while `req_ready` is 1. `req_ready` stays 0 from the clock after acceptance until the clock after `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | Window (chip select) index |
| req_addr | input | 16 | Byte offset inside the window |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables (used in 8-bit mode) |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| cfg_bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_hi_lane | input | 1 | 8-bit mode: use AD[15:8] |
| cfg_big_end | input | 1 | Big-endian byte order |
| cfg_muxed | input | 1 | Address and data share AD |
| cfg_ale_a10 | input | 1 | Separated mode: ALE pin carries address bit 10 |
| cfg_oe_en | input | 1 | Allow driving AD |
| cfg_pol | input | 4 | Pin inversion: cs, ALE, read, write |
| cfg_t_setup | input | 4 | Setup count |
| cfg_t_ale | input | 4 | ALE width count |
| cfg_t_ahold | input | 4 | Address hold count |
| cfg_t_rd | input | 4 | Read strobe count |
| cfg_t_wr | input | 4 | Write strobe count |
| cfg_t_hold | input | 4 | Hold count |
| cfg_shift_base | input | 16 | Global address shift |
| cfg_win_base | input | 32 | Per-window base, window w at [16w+15:16w] |
| cfg_win_bits | input | 10 | Per-window log2 size, window w at [5w+4:5w] |
| lb_ad_o | output | 16 | AD output value |
| lb_ad_oe | output | 1 | AD output enable |
| lb_ad_i | input | 16 | AD input value |
| lb_addr_o | output | 16 | Separate address pins |
| lb_ale_o | output | 1 | ALE pin, or address bit 10 |
| lb_rd_o | output | 1 | Read strobe pin |
| lb_wr_o | output | 1 | Write strobe pin |
| lb_cs_o | output | 2 | Chip-select pins |

## Verification
The main function is exercised in several modes:
- multiplexed 16-bit writes with unequal phase counts;
- 16-bit reads with every count at zero, in big-endian order;
- 8-bit two-byte reads on the upper lane, and 8-bit writes with each byte-enable pattern;
- separated mode, both with ALE as address bit 10 and with an ALE pulse.

Unequal counts separate the phases from one another. All-zero counts expose off-by-one errors in counter reload. Byte-enable patterns separate the ordering rule from the lane rule. The read model drives wrong data on every strobe clock except the last, so capture on any other edge returns a wrong value. Offsets just inside and just outside each window limit confirm which size rule is in force.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ALE,
      PH_AHOLD,
      PH_TURN,
      PH_STRB,
      PH_HOLD,
      PH_DONE
   } lbm_phase_e;

   localparam int POL_CS  = 0;
   localparam int POL_ALE = 1;
   localparam int POL_RD  = 2;
   localparam int POL_WR  = 3;

   localparam int A10_LIMIT = 11;
   localparam int ISA_LIMIT = 10;

endpackage

// File: rtl/lbm_addr_map.sv
module lbm_addr_map
   import lbm_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int NWIN   = 2,
   parameter int SZ_W   = 5,
   localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic [WIN_W-1:0]       win,
   input  logic [ADDR_W-1:0]      offset,
   input  logic [ADDR_W-1:0]      shift_base,
   input  logic [NWIN*ADDR_W-1:0] win_base,
   input  logic [NWIN*SZ_W-1:0]   win_bits,
   input  logic                   muxed,
   input  logic                   ale_a10,
   output logic                   hit,
   output logic [ADDR_W-1:0]      bus_addr
);

   if (ADDR_W < A10_LIMIT) begin : g_bad_addr_w
      $error("lbm_addr_map: ADDR_W too small");
   end

   logic              hit_v  [NWIN];
   logic [ADDR_W-1:0] addr_v [NWIN];

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      always_comb begin
         int lim;
         int eff;
         lim = muxed ? ADDR_W : (ale_a10 ? A10_LIMIT : ISA_LIMIT);
         eff = (int'(win_bits[w*SZ_W +: SZ_W]) < lim) ? int'(win_bits[w*SZ_W +: SZ_W]) : lim;
         hit_v[w]  = ((offset >> eff) == '0);
         addr_v[w] = offset + win_base[w*ADDR_W +: ADDR_W] + shift_base;
      end
   end

   always_comb begin
      hit      = 1'b0;
      bus_addr = '0;
      for (int w = 0; w < NWIN; w++) begin
         if (int'(win) == w) begin
            hit      = hit_v[w];
            bus_addr = addr_v[w];
         end
      end
   end

endmodule

// File: rtl/lbm_lane.sv
module lbm_lane #(
   parameter int DATA_W = 16,
   localparam int NLANE = DATA_W / 8
) (
   input  logic              bus16,
   input  logic              hi_lane,
   input  logic              big_end,
   input  logic              k,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] ad_i,
   output logic [DATA_W-1:0] wr_bus,
   output logic [DATA_W-1:0] rd_word,
   output logic [7:0]        rd_byte
);

   if (NLANE != 2) begin : g_bad_data_w
      $error("lbm_lane: only a two-lane bus is supported");
   end

   logic [7:0] host_byte;
   assign host_byte = k ? wdata[DATA_W-1 -: 8] : wdata[7:0];

   for (genvar j = 0; j < NLANE; j++) begin : g_lane
      localparam int   SWAP    = NLANE - 1 - j;
      localparam logic LANE_HI = (j == NLANE - 1);
      assign wr_bus[j*8 +: 8] =
         bus16                ? (big_end ? wdata[SWAP*8 +: 8] : wdata[j*8 +: 8]) :
         (hi_lane == LANE_HI) ? host_byte : 8'h00;
      assign rd_word[j*8 +: 8] = big_end ? ad_i[SWAP*8 +: 8] : ad_i[j*8 +: 8];
   end

   assign rd_byte = hi_lane ? ad_i[DATA_W-1 -: 8] : ad_i[7:0];

endmodule

// File: rtl/lbm_seq.sv
module lbm_seq
   import lbm_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             skip,
   input  logic             more,
   input  logic             is_write,
   input  logic             skip_ale,
   input  logic [CNT_W-1:0] t_setup,
   input  logic [CNT_W-1:0] t_ale,
   input  logic [CNT_W-1:0] t_ahold,
   input  logic [CNT_W-1:0] t_rd,
   input  logic [CNT_W-1:0] t_wr,
   input  logic [CNT_W-1:0] t_hold,
   output lbm_phase_e       phase_o,
   output logic             sample_o,
   output logic             beat_end_o
);

   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("lbm_seq: CNT_W must be positive");
   end

   lbm_phase_e       phase;
   logic [CNT_W-1:0] cnt;

   function automatic logic [CNT_W-1:0] ld(input logic [CNT_W-1:0] v);
      return (v == '0) ? '0 : v - 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (phase != PH_IDLE && phase != PH_DONE && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               if (skip) phase <= PH_DONE;
               else begin
                  phase <= PH_ADDR;
                  cnt   <= ld(t_setup);
               end
            end
            PH_ADDR: if (skip_ale) begin
               phase <= PH_AHOLD;
               cnt   <= ld(t_ahold);
            end else begin
               phase <= PH_ALE;
               cnt   <= ld(t_ale);
            end
            PH_ALE: begin
               phase <= PH_AHOLD;
               cnt   <= ld(t_ahold);
            end
            PH_AHOLD: begin
               phase <= PH_TURN;
               cnt   <= '0;
            end
            PH_TURN: begin
               phase <= PH_STRB;
               cnt   <= ld(is_write ? t_wr : t_rd);
            end
            PH_STRB: begin
               phase <= PH_HOLD;
               cnt   <= ld(t_hold);
            end
            PH_HOLD: if (more) begin
               phase <= PH_ADDR;
               cnt   <= ld(t_setup);
            end else phase <= PH_DONE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign phase_o    = phase;
   assign sample_o   = (phase == PH_STRB) && (cnt == '0) && !is_write;
   assign beat_end_o = (phase == PH_HOLD) && (cnt == '0);

   p_ale_skipped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ALE) |-> !skip_ale);
   p_done_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE) |=> (phase == PH_IDLE));
   p_turn_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TURN) |=> (phase == PH_STRB));

endmodule

// File: rtl/lbus_cycle_master.sv
module lbus_cycle_master
   import lbm_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int NWIN   = 2,
   parameter int CNT_W  = 4,
   parameter int SZ_W   = 5,
   localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1,
   localparam int BE_W  = DATA_W / 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_write,
   input  logic [WIN_W-1:0]       req_win,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   input  logic [BE_W-1:0]        req_be,
   output logic                   rsp_done,
   output logic [DATA_W-1:0]      rsp_rdata,
   input  logic                   cfg_bus16,
   input  logic                   cfg_hi_lane,
   input  logic                   cfg_big_end,
   input  logic                   cfg_muxed,
   input  logic                   cfg_ale_a10,
   input  logic                   cfg_oe_en,
   input  logic [3:0]             cfg_pol,
   input  logic [CNT_W-1:0]       cfg_t_setup,
   input  logic [CNT_W-1:0]       cfg_t_ale,
   input  logic [CNT_W-1:0]       cfg_t_ahold,
   input  logic [CNT_W-1:0]       cfg_t_rd,
   input  logic [CNT_W-1:0]       cfg_t_wr,
   input  logic [CNT_W-1:0]       cfg_t_hold,
   input  logic [ADDR_W-1:0]      cfg_shift_base,
   input  logic [NWIN*ADDR_W-1:0] cfg_win_base,
   input  logic [NWIN*SZ_W-1:0]   cfg_win_bits,
   output logic [DATA_W-1:0]      lb_ad_o,
   output logic                   lb_ad_oe,
   input  logic [DATA_W-1:0]      lb_ad_i,
   output logic [ADDR_W-1:0]      lb_addr_o,
   output logic                   lb_ale_o,
   output logic                   lb_rd_o,
   output logic                   lb_wr_o,
   output logic [NWIN-1:0]        lb_cs_o
);

   if (DATA_W != 16 || ADDR_W > DATA_W) begin : g_bad_widths
      $error("lbus_cycle_master: DATA_W must be 16 and ADDR_W must not exceed it");
   end

   lbm_phase_e        phase;
   logic              sample, beat_end;
   logic              hit, start, skip, two, k0, skip_ale;
   logic [ADDR_W-1:0] map_addr, beat_addr;
   logic [DATA_W-1:0] wr_bus, rd_word;
   logic [7:0]        rd_byte;

   logic              r_write, r_k, r_pend;
   logic [WIN_W-1:0]  r_win;
   logic [ADDR_W-1:0] r_base;
   logic [DATA_W-1:0] r_wdata, r_rdata;

   lbm_addr_map #(.ADDR_W(ADDR_W), .NWIN(NWIN), .SZ_W(SZ_W)) map_i (
      .win(req_win), .offset(req_addr), .shift_base(cfg_shift_base),
      .win_base(cfg_win_base), .win_bits(cfg_win_bits),
      .muxed(cfg_muxed), .ale_a10(cfg_ale_a10),
      .hit(hit), .bus_addr(map_addr)
   );

   lbm_lane #(.DATA_W(DATA_W)) lane_i (
      .bus16(cfg_bus16), .hi_lane(cfg_hi_lane), .big_end(cfg_big_end),
      .k(r_k), .wdata(r_wdata), .ad_i(lb_ad_i),
      .wr_bus(wr_bus), .rd_word(rd_word), .rd_byte(rd_byte)
   );

   lbm_seq #(.CNT_W(CNT_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .skip(skip), .more(r_pend),
      .is_write(r_write), .skip_ale(skip_ale),
      .t_setup(cfg_t_setup), .t_ale(cfg_t_ale), .t_ahold(cfg_t_ahold),
      .t_rd(cfg_t_rd), .t_wr(cfg_t_wr), .t_hold(cfg_t_hold),
      .phase_o(phase), .sample_o(sample), .beat_end_o(beat_end)
   );

   assign req_ready = (phase == PH_IDLE);
   assign start     = req_valid && req_ready;
   assign skip_ale  = !cfg_muxed && cfg_ale_a10;
   assign two       = !cfg_bus16 && (req_be == '1);
   assign k0        = cfg_bus16 ? 1'b0 : (two ? cfg_big_end : req_be[BE_W-1]);
   assign skip      = !hit || (!cfg_bus16 && req_be == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_write <= 1'b0;
         r_k     <= 1'b0;
         r_pend  <= 1'b0;
         r_win   <= '0;
         r_base  <= '0;
         r_wdata <= '0;
         r_rdata <= '0;
      end else if (start) begin
         r_write <= req_write;
         r_k     <= k0;
         r_pend  <= two;
         r_win   <= req_win;
         r_base  <= map_addr;
         r_wdata <= req_wdata;
         r_rdata <= '0;
      end else begin
         if (sample) begin
            if (cfg_bus16) r_rdata <= rd_word;
            else           r_rdata[r_k*8 +: 8] <= rd_byte;
         end
         if (beat_end && r_pend) begin
            r_k    <= ~r_k;
            r_pend <= 1'b0;
         end
      end
   end

   logic step;
   assign step      = cfg_bus16 ? 1'b0 : (cfg_big_end ? ~r_k : r_k);
   assign beat_addr = r_base + {{(ADDR_W-1){1'b0}}, step};

   logic busy, addr_ph;
   logic [NWIN-1:0] cs_act;
   assign busy    = (phase != PH_IDLE) && (phase != PH_DONE);
   assign addr_ph = (phase == PH_ADDR) || (phase == PH_ALE) || (phase == PH_AHOLD);

   for (genvar w = 0; w < NWIN; w++) begin : g_cs
      assign cs_act[w]  = busy && (int'(r_win) == w);
      assign lb_cs_o[w] = ~cs_act[w] ^ cfg_pol[POL_CS];
   end

   assign lb_ale_o  = skip_ale ? beat_addr[A10_LIMIT-1]
                               : ((phase == PH_ALE) ^ cfg_pol[POL_ALE]);
   assign lb_rd_o   = ~((phase == PH_STRB) && !r_write) ^ cfg_pol[POL_RD];
   assign lb_wr_o   = ~((phase == PH_STRB) &&  r_write) ^ cfg_pol[POL_WR];
   assign lb_ad_oe  = cfg_oe_en && busy && ((cfg_muxed && addr_ph) || r_write);
   assign lb_ad_o   = (cfg_muxed && addr_ph) ? DATA_W'(beat_addr) : wr_bus;
   assign lb_addr_o = beat_addr;
   assign rsp_done  = (phase == PH_DONE);
   assign rsp_rdata = r_rdata;

   p_start_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !req_ready);
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> (!rsp_done && req_ready));
   p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_STRB) && !r_write) |-> !lb_ad_oe);
   p_sample_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sample |-> (lb_rd_o == cfg_pol[POL_RD]));
   p_oe_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_oe_en |-> !lb_ad_oe);
   p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_act));
   p_reject_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && skip) |=> (rsp_done && cs_act == '0));

endmodule

// File: tb/lbus_cycle_master_tb.sv
`timescale 1ns/1ps
module lbus_cycle_master_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic        req_win = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_ready, rsp_done;
   logic [15:0] rsp_rdata;
   logic        cfg_bus16 = 1'b1, cfg_hi_lane = 1'b0, cfg_big_end = 1'b0;
   logic        cfg_muxed = 1'b1, cfg_ale_a10 = 1'b0, cfg_oe_en = 1'b1;
   logic [3:0]  cfg_pol = '0;
   logic [3:0]  t_setup = 4'd1, t_ale = 4'd1, t_ahold = 4'd1;
   logic [3:0]  t_rd = 4'd1, t_wr = 4'd1, t_hold = 4'd1;
   logic [15:0] cfg_shift_base = '0;
   logic [31:0] cfg_win_base = '0;
   logic [9:0]  cfg_win_bits = {5'd16, 5'd16};
   logic [15:0] lb_ad_o, lb_addr_o;
   logic [15:0] lb_ad_i = 16'hDEAD;
   logic        lb_ad_oe, lb_ale_o, lb_rd_o, lb_wr_o;
   logic [1:0]  lb_cs_o;

   always #2.5 clk = ~clk;

   lbus_cycle_master dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_win(req_win), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .cfg_bus16(cfg_bus16), .cfg_hi_lane(cfg_hi_lane), .cfg_big_end(cfg_big_end),
      .cfg_muxed(cfg_muxed), .cfg_ale_a10(cfg_ale_a10), .cfg_oe_en(cfg_oe_en),
      .cfg_pol(cfg_pol), .cfg_t_setup(t_setup), .cfg_t_ale(t_ale),
      .cfg_t_ahold(t_ahold), .cfg_t_rd(t_rd), .cfg_t_wr(t_wr), .cfg_t_hold(t_hold),
      .cfg_shift_base(cfg_shift_base), .cfg_win_base(cfg_win_base),
      .cfg_win_bits(cfg_win_bits), .lb_ad_o(lb_ad_o), .lb_ad_oe(lb_ad_oe),
      .lb_ad_i(lb_ad_i), .lb_addr_o(lb_addr_o), .lb_ale_o(lb_ale_o),
      .lb_rd_o(lb_rd_o), .lb_wr_o(lb_wr_o), .lb_cs_o(lb_cs_o)
   );

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   int rd_cycles, wr_cycles, ale_cycles, cs0_cycles, cs1_cycles, a10_bad, oe_seen, rd_oe_bad;
   int nstb, rd_run, exp_rd_len, lat;
   logic [15:0] mux_addr_seen;
   logic [15:0] log_addr [4];
   logic [15:0] log_wdata [4];
   logic ready_after, prev_stb;
   logic [15:0] got_rdata;

   function automatic logic [15:0] model(input logic [15:0] a);
      return {~a[7:0], a[7:0]};
   endfunction

   // Bus-side model and monitor, acting between clock edges
   always @(negedge clk) begin
      logic rd_act, wr_act, ale_act;
      rd_act  = (lb_rd_o == cfg_pol[2]);
      wr_act  = (lb_wr_o == cfg_pol[3]);
      ale_act = !(!cfg_muxed && cfg_ale_a10) && (lb_ale_o == ~cfg_pol[1]);
      if (lb_cs_o[0] == cfg_pol[0]) cs0_cycles++;
      if (lb_cs_o[1] == cfg_pol[0]) cs1_cycles++;
      if (lb_ad_oe) oe_seen++;
      if (ale_act) begin
         ale_cycles++;
         mux_addr_seen = lb_ad_o;
      end
      if (!cfg_muxed && cfg_ale_a10 && (lb_cs_o != {2{~cfg_pol[0]}}) && (lb_ale_o != lb_addr_o[10]))
         a10_bad++;
      if ((rd_act || wr_act) && !prev_stb && nstb < 4) begin
         log_addr[nstb]  = lb_addr_o;
         log_wdata[nstb] = lb_ad_o;
         nstb++;
      end
      prev_stb = rd_act || wr_act;
      if (wr_act) wr_cycles++;
      if (rd_act) begin
         rd_cycles++;
         rd_run++;
         if (lb_ad_oe) rd_oe_bad++;
         lb_ad_i = (rd_run == exp_rd_len) ? model(lb_addr_o) : 16'hDEAD;
      end else begin
         rd_run  = 0;
         lb_ad_i = 16'hDEAD;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_txn(input logic win, input logic wr, input logic [15:0] addr,
                          input logic [15:0] wd, input logic [1:0] be);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      rd_cycles = 0; wr_cycles = 0; ale_cycles = 0; cs0_cycles = 0; cs1_cycles = 0;
      a10_bad = 0; oe_seen = 0; rd_oe_bad = 0; nstb = 0; mux_addr_seen = 'x;
      req_valid = 1; req_win = win; req_write = wr; req_addr = addr;
      req_wdata = wd; req_be = be;
      @(negedge clk);
      req_valid = 0;
      ready_after = req_ready;
      lat = 0;
      while (!rsp_done) begin
         lat++;
         @(negedge clk);
      end
      got_rdata = rsp_rdata;
      @(negedge clk);
   endtask

   function automatic int one(input logic [3:0] v);
      return (v == 0) ? 1 : int'(v);
   endfunction

   task automatic t_reset;
      chk("R1 ready", req_ready, 1);
      chk("R1 done", rsp_done, 0);
      chk("R1 cs pins", lb_cs_o, 2'b11);
      chk("R1 strobes", {lb_rd_o, lb_wr_o, lb_ale_o}, 3'b110);
      chk("R1 oe", lb_ad_oe, 0);
   endtask

   task automatic t_mux_write16;
      cfg_bus16 = 1; cfg_muxed = 1; cfg_big_end = 0;
      t_setup = 2; t_ale = 1; t_ahold = 1; t_wr = 3; t_hold = 2;
      cfg_shift_base = 16'h0100; cfg_win_base = {16'h2000, 16'h0040};
      run_txn(0, 1, 16'h0012, 16'hBEEF, 2'b11);
      chk("R5 mux address on AD", mux_addr_seen, 16'h0152);
      chk("R2 bus address", log_addr[0], 16'h0152);
      chk("R7 little write word", log_wdata[0], 16'hBEEF);
      chk("R4 write strobe length", wr_cycles, 3);
      chk("R4 latency", lat, 2 + 1 + 1 + 1 + 3 + 2);
      chk("R2 cs0 span", cs0_cycles, lat);
      chk("R2 cs1 idle", cs1_cycles, 0);
      chk("R6 one ale pulse", ale_cycles, 1);
      chk("R13 ready low after accept", ready_after, 0);
   endtask

   task automatic t_zero_read16;
      cfg_big_end = 1;
      t_setup = 0; t_ale = 0; t_ahold = 0; t_rd = 0; t_hold = 0;
      exp_rd_len = 1;
      run_txn(1, 0, 16'h0020, 16'h0, 2'b11);
      chk("R4 zero count read strobe", rd_cycles, 1);
      chk("R4 zero count latency", lat, 6);
      chk("R7 R10 big endian read", got_rdata, 16'h20DF);
      chk("R5 bus released on read", rd_oe_bad, 0);
      chk("R2 cs1 span", cs1_cycles, 6);
      chk("R2 cs0 idle", cs0_cycles, 0);
   endtask

   task automatic t_byte_read;
      cfg_bus16 = 0; cfg_big_end = 0; cfg_hi_lane = 1;
      t_setup = 1; t_ale = 1; t_ahold = 1; t_rd = 3; t_hold = 1;
      exp_rd_len = 3;
      run_txn(0, 0, 16'h0010, 16'h0, 2'b11);
      chk("R8 two byte cycles", nstb, 2);
      chk("R8 first address", log_addr[0], 16'h0150);
      chk("R8 second address", log_addr[1], 16'h0151);
      chk("R9 R10 assembled read", got_rdata, 16'hAEAF);
      chk("R4 strobe clocks", rd_cycles, 6);
   endtask

   task automatic t_byte_write;
      cfg_big_end = 1; cfg_hi_lane = 0;
      run_txn(0, 1, 16'h0010, 16'h1234, 2'b11);
      chk("R8 big first address", log_addr[0], 16'h0150);
      chk("R9 R8 big first byte", log_wdata[0], 16'h0012);
      chk("R9 R8 big second byte", log_wdata[1], 16'h0034);
      run_txn(0, 1, 16'h0010, 16'h1234, 2'b01);
      chk("R8 single byte count", nstb, 1);
      chk("R8 single byte address", log_addr[0], 16'h0151);
      run_txn(0, 1, 16'h0010, 16'h1234, 2'b00);
      chk("R8 no enables no cycle", nstb, 0);
      chk("R8 no enables latency", lat, 0);
   endtask

   task automatic t_sep_a10;
      cfg_bus16 = 1; cfg_big_end = 0; cfg_muxed = 0; cfg_ale_a10 = 1;
      cfg_shift_base = 0; cfg_win_base = '0;
      t_setup = 1; t_ahold = 2; t_wr = 2; t_hold = 1;
      run_txn(0, 1, 16'h0500, 16'hA5C3, 2'b11);
      chk("R6 no ale pulse", ale_cycles, 0);
      chk("R6 ale is bit 10", a10_bad, 0);
      chk("R6 pin high for bit 10", lb_ale_o, 1);
      chk("R7 separated data", log_wdata[0], 16'hA5C3);
      chk("R4 latency without ale", lat, 1 + 2 + 1 + 2 + 1);
      run_txn(0, 0, 16'h0800, 16'h0, 2'b11);
      chk("R3 2KB limit no strobe", nstb, 0);
      chk("R3 2KB limit no cs", cs0_cycles, 0);
      chk("R3 reject latency", lat, 0);
   endtask

   task automatic t_isa;
      cfg_ale_a10 = 0;
      t_setup = 1; t_ale = 1; t_ahold = 1; t_rd = 1; t_hold = 1;
      exp_rd_len = 1;
      run_txn(0, 0, 16'h03FF, 16'h0, 2'b11);
      chk("R3 1KB edge accepted", nstb, 1);
      chk("R6 ale pulse present", ale_cycles, 1);
      chk("R10 separated read", got_rdata, 16'h00FF);
      run_txn(0, 0, 16'h0400, 16'h0, 2'b11);
      chk("R3 1KB limit rejected", nstb, 0);
      chk("R3 rejected read data", got_rdata, 16'h0000);
   endtask

   task automatic t_resize;
      cfg_muxed = 1;
      cfg_win_bits = {5'd16, 5'd4};
      run_txn(0, 0, 16'h000F, 16'h0, 2'b11);
      chk("R3 resized edge accepted", nstb, 1);
      run_txn(0, 0, 16'h0010, 16'h0, 2'b11);
      chk("R3 resized limit rejected", nstb, 0);
      cfg_win_bits = {5'd16, 5'd16};
   endtask

   task automatic t_polarity;
      cfg_pol = 4'b1111;
      @(negedge clk);
      chk("R11 idle cs inverted", lb_cs_o, 2'b00);
      chk("R11 idle pins inverted", {lb_rd_o, lb_wr_o, lb_ale_o}, 3'b001);
      t_rd = 2; exp_rd_len = 2;
      run_txn(0, 0, 16'h0004, 16'h0, 2'b11);
      chk("R11 inverted read strobe", rd_cycles, 2);
      chk("R11 inverted ale", ale_cycles, 1);
      chk("R11 inverted cs span", cs0_cycles, lat);
      cfg_pol = 4'b0000;
   endtask

   task automatic t_oe_off;
      cfg_oe_en = 0; t_wr = 2;
      run_txn(0, 1, 16'h0006, 16'h5A5A, 2'b11);
      chk("R12 bus never driven", oe_seen, 0);
      chk("R12 strobe still runs", wr_cycles, 2);
      cfg_oe_en = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_mux_write16();
      t_zero_read16();
      t_byte_read();
      t_byte_write();
      t_sep_a10();
      t_isa();
      t_resize();
      t_polarity();
      t_oe_off();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule